// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Port

This block holds twelve 8-bit chipset configuration registers. Software reaches them through two I/O locations. It first writes a register number to the index location, then makes one read or one write at the data location. The block decodes single-cycle I/O read and write strobes against a full I/O address. It latches the register number, and then serves exactly one data access to the selected register. That access uses up the latched number, so every data access needs its own fresh index write, even when the same register is accessed again.

Each register has a reset value, a mask of implemented bits and, where needed, read-only bits. All twelve register bytes are also driven in parallel on an export bus for the logic that consumes them. Two behaviours shape that export. First, the two-bit clock-select field takes its reset value from a strap pin sampled while reset is held. Second, the fast-decode control is exported as off whenever the cache-enable control is on, whatever value was written to it.

Top module: `cfg_index_port`

## Requirements
- R1: After reset, registers 20h..2Bh hold 40h, 00h, 84h, 00h, 87h, F0h plus strap, 00h, 91h, 80h, 00h, 80h, 00h, both on readback and on the export bus. Byte k of `cfg_export` (bits 8k+7:8k) is register 20h+k.
- R2: Bits 7:6 of register 20h are read-only and always read as 01. Writes to them have no effect.
- R3: Unimplemented bits read as 0 and are exported as 0. The implemented-bit masks are: 20h 3Fh (writable part), 22h FDh, 24h F7h, 25h FBh, 26h 7Fh, 27h 9Fh, 28h E3h, 2Ah E3h. Registers 21h, 23h, 29h and 2Bh implement all eight bits.
- R4: Any data-location access marks the index invalid. While the index is invalid, a data write is dropped and a data read returns FFh.
- R5: A valid index outside 20h..2Bh does not claim the data location. A read then returns FFh and a write changes no register.
- R6: Bits 1:0 of register 25h read as {0, strap} as the strap was sampled during reset, until software writes register 25h. After that write they read the written value.
- R7: When bit 4 of register 21h is 1, bit 3 of export byte 25h is 0. Readback of register 25h still returns the stored bit 3.
- R8: An index write at 0022h followed by a data write at 0024h updates the register and its export byte at the clock edge of the data write. A later index write plus data read returns the stored value in the cycle the read strobe is high.
- R9: Strobes at any address other than 0022h and 0024h change neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_sel_strap | input | 1 | Strap that sets the reset value of the register 25h clock-select field |
| io_addr | input | ADDR_W (16) | I/O address of the current cycle |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rdata | output | 8 | Read data, valid while a data-location read strobe is high, FFh otherwise |
| cfg_export | output | 8*NREG (96) | Effective value of every register, byte k for register 20h+k |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. Register contents, the export bus and the index state change on the rising edge that ends a write strobe, so they are due one edge after it. Reset values appear two edges after `rst_n` rises, because the reset release is synchronised. The bench drives every strobe on the falling edge. It samples reads 1 ns later, in the same cycle. It samples export bytes on the falling edge after the write edge. This keeps every check a half cycle away from any active edge.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int          NREG     = 12;
  localparam logic [7:0]  IDX_BASE = 8'h20;
  localparam int          SEL_W    = $clog2(NREG);
  localparam int          CLKSEL_K = 5;  // register 25h
  localparam int          CACHE_K  = 1;  // register 21h
  localparam int          CACHE_B  = 4;
  localparam int          FASTD_B  = 3;

  // Bits that a data write may change
  function automatic logic [7:0] wr_mask(input int k);
    case (k)
      0:       wr_mask = 8'h3F;
      2:       wr_mask = 8'hFD;
      4:       wr_mask = 8'hF7;
      5:       wr_mask = 8'hFB;
      6:       wr_mask = 8'h7F;
      7:       wr_mask = 8'h9F;
      8, 10:   wr_mask = 8'hE3;
      default: wr_mask = 8'hFF;
    endcase
  endfunction

  // Fixed bits forced into the stored value
  function automatic logic [7:0] ro_bits(input int k);
    ro_bits = (k == 0) ? 8'h40 : 8'h00;
  endfunction

  function automatic logic [7:0] rst_val(input int k);
    case (k)
      0:       rst_val = 8'h40;
      2:       rst_val = 8'h84;
      4:       rst_val = 8'h87;
      5:       rst_val = 8'hF0;
      7:       rst_val = 8'h91;
      8, 10:   rst_val = 8'h80;
      default: rst_val = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_io_decode.sv
module cfg_io_decode
  import cfg_port_pkg::*;
#(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h22,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              reg_we,
  output logic              reg_rd,
  output logic [SEL_W-1:0]  reg_sel,
  output logic              idx_vld
);
  logic       idx_vld_q, idx_vld_d, idx_en;
  logic [7:0] idx_q, idx_d;
  logic       hit_index, hit_data, in_range;
  logic [7:0] offset;

  assign hit_index = (io_addr == INDEX_ADDR);
  assign hit_data  = (io_addr == DATA_ADDR);
  assign offset    = idx_q - IDX_BASE;
  assign in_range  = (idx_q >= IDX_BASE) && (offset < 8'(NREG));

  always_comb begin
    idx_en    = 1'b0;
    idx_d     = idx_q;
    idx_vld_d = idx_vld_q;
    if (io_wr && hit_index) begin
      idx_en    = 1'b1;
      idx_d     = io_wdata;
      idx_vld_d = 1'b1;
    end else if ((io_rd || io_wr) && hit_data) begin
      idx_en    = 1'b1;
      idx_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      idx_vld_q <= 1'b0;
    end else if (idx_en) begin
      idx_q     <= idx_d;
      idx_vld_q <= idx_vld_d;
    end
  end

  assign reg_we  = io_wr && hit_data && idx_vld_q && in_range;
  assign reg_rd  = io_rd && hit_data && idx_vld_q && in_range;
  assign reg_sel = offset[SEL_W-1:0];
  assign idx_vld = idx_vld_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [7:0]        wdata,
  output logic [NREG*8-1:0] rb_data,
  output logic [NREG*8-1:0] ex_data
);
  logic [7:0] store_q [NREG];
  logic       strap_q;
  logic       clksel_wr_q, clksel_wr_d;

  // Strap captured on every clock while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic       en;
    logic [7:0] nxt;
    always_comb begin
      en  = reg_we && (reg_sel == SEL_W'(k));
      nxt = (wdata & wr_mask(k)) | ro_bits(k);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  store_q[k] <= rst_val(k);
      else if (en) store_q[k] <= nxt;
    end
    if (k == CLKSEL_K) begin : g_clksel
      assign rb_data[k*8 +: 8] = {store_q[k][7:2],
                                  clksel_wr_q ? store_q[k][1:0] : {1'b0, strap_q}};
    end else begin : g_plain
      assign rb_data[k*8 +: 8] = store_q[k];
    end
  end

  assign clksel_wr_d = clksel_wr_q | (reg_we && (reg_sel == SEL_W'(CLKSEL_K)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clksel_wr_q <= 1'b0;
    else        clksel_wr_q <= clksel_wr_d;
  end

  // Cross-register override applied on the export side only
  always_comb begin
    ex_data = rb_data;
    if (rb_data[CACHE_K*8 + CACHE_B])
      ex_data[CLKSEL_K*8 + FASTD_B] = 1'b0;
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h22,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_sel_strap,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic [NREG*8-1:0] cfg_export
);
  logic             rst_sync_n;
  logic             reg_we, reg_rd, idx_vld;
  logic [SEL_W-1:0] reg_sel;
  logic [NREG*8-1:0] rb_data;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cfg_io_decode #(
    .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_sync_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .reg_we(reg_we), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .idx_vld(idx_vld)
  );

  cfg_reg_bank u_bank (
    .clk(clk), .rst_n(rst_sync_n), .strap(clk_sel_strap), .reg_we(reg_we),
    .reg_sel(reg_sel), .wdata(io_wdata), .rb_data(rb_data), .ex_data(cfg_export)
  );

  always_comb begin
    io_rdata = 8'hFF;
    for (int k = 0; k < NREG; k++)
      if (reg_rd && (reg_sel == SEL_W'(k))) io_rdata = rb_data[k*8 +: 8];
  end
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk
  import cfg_port_pkg::*;
#(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h22,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_rdata,
  input logic              idx_vld,
  input logic [NREG*8-1:0] cfg_export
);
  logic data_acc, index_wr;
  assign data_acc = (io_rd || io_wr) && (io_addr == DATA_ADDR);
  assign index_wr = io_wr && (io_addr == INDEX_ADDR);

  p_rev_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_export[7:6] == 2'b01);

  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_export[2*8+1] && !cfg_export[4*8+3] && !cfg_export[5*8+2] &&
    !cfg_export[6*8+7] && (cfg_export[7*8+6 -: 2] == 2'b00) &&
    (cfg_export[8*8+4 -: 3] == 3'b000) && (cfg_export[10*8+4 -: 3] == 3'b000));

  p_fast_decode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_export[CACHE_K*8 + CACHE_B] |-> !cfg_export[CLKSEL_K*8 + FASTD_B]);

  p_index_used_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> !idx_vld);

  p_index_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    index_wr |=> idx_vld);

  p_noidx_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (io_addr == DATA_ADDR) && !idx_vld) |-> (io_rdata == 8'hFF));

  p_noidx_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr == DATA_ADDR) && !idx_vld) |=> $stable(cfg_export));

  p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != DATA_ADDR) |-> (io_rdata == 8'hFF));
endmodule

bind cfg_index_port cfg_index_port_chk #(
  .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .io_addr(io_addr), .io_rd(io_rd),
  .io_wr(io_wr), .io_rdata(io_rdata), .idx_vld(idx_vld), .cfg_export(cfg_export)
);

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;
  localparam logic [15:0] IDXA = 16'h0022;
  localparam logic [15:0] DATA = 16'h0024;

  logic        clk = 1'b0;
  logic        rst_n, strap, io_rd, io_wr;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic [95:0] cfg_export;
  int          n_cmp = 0, n_bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cfg_index_port u_cfg_index_port (
    .clk(clk), .rst_n(rst_n), .clk_sel_strap(strap), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
    .cfg_export(cfg_export)
  );

  // {index, write data, expected readback}
  localparam logic [23:0] VEC [12] = '{
    24'h20A565, 24'h213C3C, 24'h22FFFD, 24'h235A5A, 24'h24FFF7, 24'h25FFFB,
    24'h26FF7F, 24'h27FF9F, 24'h28FFE3, 24'h29C3C3, 24'h2A1C00, 24'h2B8181
  };
  localparam logic [7:0] DEF [12] = '{
    8'h40, 8'h00, 8'h84, 8'h00, 8'h87, 8'hF0,
    8'h00, 8'h91, 8'h80, 8'h00, 8'h80, 8'h00
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    io_write(IDXA, idx);
    io_read(DATA, d);
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap = s; io_rd = 1'b0; io_wr = 1'b0;
    io_addr = '0; io_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] rd;
    logic [95:0] snap;

    // R1 / R6: reset values with strap high
    do_reset(1'b1);
    for (int k = 0; k < 12; k++)
      chk("R1 export default", cfg_export[k*8 +: 8], (k == 5) ? 8'hF1 : DEF[k]);
    for (int k = 0; k < 12; k++) begin
      reg_read(8'h20 + 8'(k), rd);
      chk("R1 readback default", rd, (k == 5) ? 8'hF1 : DEF[k]);
    end

    // R2 / R3 / R8: table of write then read
    for (int k = 0; k < 12; k++) begin
      io_write(IDXA, VEC[k][23:16]);
      io_write(DATA, VEC[k][15:8]);
      @(negedge clk);
      if (k != 5) chk("R8 export after write", cfg_export[k*8 +: 8], VEC[k][7:0]);
      reg_read(VEC[k][23:16], rd);
      chk("R3 masked readback", rd, VEC[k][7:0]);
    end
    io_write(IDXA, 8'h20); io_write(DATA, 8'h00);
    reg_read(8'h20, rd);
    chk("R2 revision bits kept", rd, 8'h40);

    // R7: fast decode forced off while cache enabled (21h bit4 = 1)
    io_write(IDXA, 8'h21); io_write(DATA, 8'h10);
    io_write(IDXA, 8'h25); io_write(DATA, 8'h08);
    @(negedge clk);
    chk("R7 export forced off", cfg_export[5*8 +: 8], 8'h00);
    reg_read(8'h25, rd);
    chk("R7 readback keeps bit", rd, 8'h08);
    io_write(IDXA, 8'h21); io_write(DATA, 8'h00);
    @(negedge clk);
    chk("R7 export released", cfg_export[5*8 +: 8], 8'h08);

    // R6: written clock select overrides strap
    io_write(IDXA, 8'h25); io_write(DATA, 8'h02);
    reg_read(8'h25, rd);
    chk("R6 written clksel", rd, 8'h02);

    // R4: index used up by each access
    io_write(IDXA, 8'h23); io_write(DATA, 8'h11);
    io_write(DATA, 8'h22);
    @(negedge clk);
    chk("R4 second write dropped", cfg_export[3*8 +: 8], 8'h11);
    io_read(DATA, rd);
    chk("R4 read without index", rd, 8'hFF);
    reg_read(8'h23, rd);
    io_read(DATA, rd);
    chk("R4 repeat read no index", rd, 8'hFF);

    // R5: out-of-range index
    snap = cfg_export;
    io_write(IDXA, 8'h30); io_write(DATA, 8'h55);
    @(negedge clk);
    chk("R5 write dropped lo", snap[47:0] == cfg_export[47:0] ? 8'h01 : 8'h00, 8'h01);
    chk("R5 write dropped hi", snap[95:48] == cfg_export[95:48] ? 8'h01 : 8'h00, 8'h01);
    reg_read(8'h1F, rd);
    chk("R5 read below range", rd, 8'hFF);
    reg_read(8'h2C, rd);
    chk("R5 read above range", rd, 8'hFF);

    // R9: other addresses leave index and registers alone
    io_write(IDXA, 8'h23);
    io_write(16'h0023, 8'h99);
    io_write(16'h0122, 8'h29);
    @(negedge clk);
    chk("R9 stray write no effect", cfg_export[3*8 +: 8], 8'h11);
    io_write(DATA, 8'h42);
    @(negedge clk);
    chk("R9 index survived stray", cfg_export[3*8 +: 8], 8'h42);
    chk("R9 reg 29h untouched", cfg_export[9*8 +: 8], 8'hC3);

    // R6: strap low on a second reset
    do_reset(1'b0);
    chk("R6 strap low export", cfg_export[5*8 +: 8], 8'hF0);
    reg_read(8'h25, rd);
    chk("R6 strap low readback", rd, 8'hF0);
    chk("R1 reg 23h back to default", cfg_export[3*8 +: 8], 8'h00);

    done = 1'b1;
    summary();
  end
endmodule